// File: doc/BRIEF.md
# Performance Monitor Error Counter Bank

This block gathers line-quality error events for a single T1/J1 framer. It keeps two live accumulators. The block error accumulator is 12 bits wide and the framing error accumulator is 9 bits wide. Their contents are copied as a group into read-only holding registers whenever a latch event occurs. A host reads the holding registers byte by byte over a small parallel register bus.

The framer delivers single-cycle pulses. One pulse marks a CRC-6 mismatch in the extended superframe format. The other marks a bit error in the frame alignment pattern. A mode input selects which pulse feeds the block error count. The framing error count always follows the frame alignment pattern pulse.

Three sources can latch the counts:
- a host write to any of this bank's four count addresses;
- the one-second tick, while auto-update is enabled;
- a chip-wide update strobe, which is shared by all framers so that they capture together.

Each latch restarts accumulation. The design merges triggers that arrive in the same cycle into a single latch, and it does not lose an error pulse that arrives in the latch cycle.

Top module: `pmon_err_bank`

## Requirements
- R1: After reset, both accumulators are zero and `host_rdata` is 0x00. The design clears the holding registers at reset, but software must not rely on them before the first latch.
- R2: With `esf_mode`=1, each cycle with `crc_err`=1 adds one to the block error count, and `fas_err` has no effect on the block error count.
- R3: With `esf_mode`=0, each cycle with `fas_err`=1 adds one to the block error count, and `crc_err` has no effect.
- R4: In both modes, each cycle with `fas_err`=1 adds one to the framing error count.
- R5: A cycle with `host_cs`=1 and `host_wr`=1 latches both accumulators together, whatever the value of `host_addr`.
- R6: A cycle with `sec_tick`=1 latches the counts when `auto_en`=1. While `auto_en`=0, the tick leaves the holding registers unchanged.
- R7: A cycle with `global_upd`=1 latches the counts.
- R8: On a latch, the holding registers take the counts accumulated before that cycle. The accumulators then restart. An event that arrives in the latch cycle counts as 1 in the new interval.
- R9: Each accumulator saturates at its all-ones value and does not wrap: 4095 for the block count and 511 for the framing count.
- R10: When several latch triggers occur in the same cycle, they produce exactly one latch, and that latch clears the accumulators once.
- R11: The register map is as follows:
  - address 0 holds block count bits [7:0];
  - address 1 holds block count bits [11:8] in bits [3:0], with zeros above;
  - address 2 holds framing count bits [7:0];
  - address 3 holds framing count bit [8] in bit 0, with zeros above.
  A cycle with `host_cs`=1 and `host_rd`=1 loads `host_rdata` on that clock edge. Between latches, the holding registers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| esf_mode | input | 1 | 1: extended superframe, 0: superframe |
| crc_err | input | 1 | CRC-6 mismatch pulse |
| fas_err | input | 1 | Frame alignment pattern bit error pulse |
| sec_tick | input | 1 | One-second tick |
| auto_en | input | 1 | Enables latching on the one-second tick |
| global_upd | input | 1 | Chip-wide latch strobe |
| host_cs | input | 1 | Selects this bank's registers |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_addr | input | 2 | Count register address |
| host_rdata | output | 8 | Registered read data |

## Verification
Two things can fall into the same cycle: counting an error event and latching the counts. A third case is two or more latch triggers arriving together. The bench drives a global strobe together with both error pulses. It then checks two results: the captured counts exclude that cycle's events, and the next interval starts at one. It also fires a host write, an enabled tick and a global strobe together. It then checks that the captured values are right and that an immediate second latch finds zeroed accumulators.

// File: rtl/pmon_pkg.sv
package pmon_pkg;
   typedef enum logic [1:0] {
      REG_BLK_LO = 2'd0,
      REG_BLK_HI = 2'd1,
      REG_FRM_LO = 2'd2,
      REG_FRM_HI = 2'd3
   } pmon_reg_e;

   localparam int unsigned HOLD_BYTES = 2;
   localparam int unsigned HOLD_MAX_W = 8 * HOLD_BYTES;
endpackage

// File: rtl/pmon_sat_counter.sv
module pmon_sat_counter #(
   parameter int unsigned W        = 12,
   parameter bit          SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
   localparam logic [W-1:0] CNT_ONE = W'(1);

   if (W < 1) begin : g_bad_w
      $error("pmon_sat_counter: W must be at least 1");
   end

   logic [W-1:0] nxt;

   if (SATURATE) begin : g_sat
      always_comb nxt = (cnt == CNT_MAX) ? cnt : cnt + CNT_ONE;
   end else begin : g_wrap
      always_comb nxt = cnt + CNT_ONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= inc ? CNT_ONE : '0;
      else if (inc) cnt <= nxt;
   end

   // R8: a clear restarts at the event of the clear cycle
   assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt <= CNT_ONE));

   // R2: no event and no clear leaves the count alone
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !inc) |=> $stable(cnt));

   if (SATURATE) begin : g_sat_chk
      assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));
   end
endmodule

// File: rtl/pmon_hold_reg.sv
module pmon_hold_reg #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= d;
   end

   // R11: holding register changes only on a latch
   assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));
endmodule

// File: rtl/pmon_latch_ctrl.sv
module pmon_latch_ctrl (
   input  logic host_wr_hit,
   input  logic sec_tick,
   input  logic auto_en,
   input  logic global_upd,
   output logic latch
);
   logic tick_hit;

   always_comb begin
      tick_hit = sec_tick & auto_en;
      latch    = host_wr_hit | tick_hit | global_upd;
   end
endmodule

// File: rtl/pmon_reg_mux.sv
module pmon_reg_mux
   import pmon_pkg::*;
#(
   parameter int unsigned BLK_W = 12,
   parameter int unsigned FRM_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_hit,
   input  logic [1:0]       addr,
   input  logic [BLK_W-1:0] hold_blk,
   input  logic [FRM_W-1:0] hold_frm,
   output logic [7:0]       rdata
);
   localparam int unsigned BLK_HI_BITS = (BLK_W > 8) ? BLK_W - 8 : 0;
   localparam int unsigned FRM_HI_BITS = (FRM_W > 8) ? FRM_W - 8 : 0;
   localparam logic [7:0]  BLK_HI_MASK = 8'((1 << BLK_HI_BITS) - 1);
   localparam logic [7:0]  FRM_HI_MASK = 8'((1 << FRM_HI_BITS) - 1);

   logic [HOLD_MAX_W-1:0] blk_ext;
   logic [HOLD_MAX_W-1:0] frm_ext;
   logic [7:0]            sel;

   always_comb begin
      blk_ext = HOLD_MAX_W'(hold_blk);
      frm_ext = HOLD_MAX_W'(hold_frm);
      unique case (pmon_reg_e'(addr))
         REG_BLK_LO: sel = blk_ext[7:0];
         REG_BLK_HI: sel = blk_ext[15:8];
         REG_FRM_LO: sel = frm_ext[7:0];
         REG_FRM_HI: sel = frm_ext[15:8];
         default:    sel = 8'h00;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      rdata <= 8'h00;
      else if (rd_hit) rdata <= sel;
   end

   // R11: reserved upper bits of the high bytes read as zero
   assert_blk_pad_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && addr == REG_BLK_HI) |=> ((rdata & ~BLK_HI_MASK) == 8'h00));
   assert_frm_pad_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && addr == REG_FRM_HI) |=> ((rdata & ~FRM_HI_MASK) == 8'h00));
   assert_rd_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_hit |=> $stable(rdata));
endmodule

// File: rtl/pmon_err_bank.sv
module pmon_err_bank
   import pmon_pkg::*;
#(
   parameter int unsigned BLK_W    = 12,
   parameter int unsigned FRM_W    = 9,
   parameter bit          SATURATE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       esf_mode,
   input  logic       crc_err,
   input  logic       fas_err,
   input  logic       sec_tick,
   input  logic       auto_en,
   input  logic       global_upd,
   input  logic       host_cs,
   input  logic       host_wr,
   input  logic       host_rd,
   input  logic [1:0] host_addr,
   output logic [7:0] host_rdata
);
   if (BLK_W < 1 || BLK_W > HOLD_MAX_W) begin : g_bad_blk
      $error("pmon_err_bank: BLK_W must fit two bytes");
   end
   if (FRM_W < 1 || FRM_W > HOLD_MAX_W) begin : g_bad_frm
      $error("pmon_err_bank: FRM_W must fit two bytes");
   end

   logic             wr_hit, rd_hit, latch;
   logic             blk_inc;
   logic [BLK_W-1:0] acc_blk, hold_blk;
   logic [FRM_W-1:0] acc_frm, hold_frm;

   always_comb begin
      wr_hit  = host_cs & host_wr;
      rd_hit  = host_cs & host_rd;
      blk_inc = esf_mode ? crc_err : fas_err;
   end

   pmon_latch_ctrl u_latch (
      .host_wr_hit (wr_hit),
      .sec_tick    (sec_tick),
      .auto_en     (auto_en),
      .global_upd  (global_upd),
      .latch       (latch)
   );

   pmon_sat_counter #(.W(BLK_W), .SATURATE(SATURATE)) u_acc_blk (
      .clk (clk), .rst_n (rst_n), .inc (blk_inc), .clr (latch), .cnt (acc_blk)
   );

   pmon_sat_counter #(.W(FRM_W), .SATURATE(SATURATE)) u_acc_frm (
      .clk (clk), .rst_n (rst_n), .inc (fas_err), .clr (latch), .cnt (acc_frm)
   );

   pmon_hold_reg #(.W(BLK_W)) u_hold_blk (
      .clk (clk), .rst_n (rst_n), .load (latch), .d (acc_blk), .q (hold_blk)
   );

   pmon_hold_reg #(.W(FRM_W)) u_hold_frm (
      .clk (clk), .rst_n (rst_n), .load (latch), .d (acc_frm), .q (hold_frm)
   );

   pmon_reg_mux #(.BLK_W(BLK_W), .FRM_W(FRM_W)) u_mux (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_hit   (rd_hit),
      .addr     (host_addr),
      .hold_blk (hold_blk),
      .hold_frm (hold_frm),
      .rdata    (host_rdata)
   );

   // R5: a host write captures both pre-latch accumulator values
   assert_wr_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_cs && host_wr) |=> (hold_blk == $past(acc_blk) && hold_frm == $past(acc_frm)));

   // R7: the global strobe captures the block count
   assert_global_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
      global_upd |=> (hold_blk == $past(acc_blk)));

   // R6: a tick with auto-update off and no other trigger changes nothing
   assert_tick_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !auto_en && !global_upd && !(host_cs && host_wr))
         |=> ($stable(hold_blk) && $stable(hold_frm)));

   // R3: in SF mode a lone CRC pulse leaves the block count unchanged
   assert_sf_ignores_crc_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!esf_mode && crc_err && !fas_err && !latch) |=> $stable(acc_blk));
endmodule

// File: tb/pmon_err_bank_tb_top.sv
`timescale 1ns/1ps
module pmon_err_bank_tb_top;
   localparam time CLK_P = 20ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       esf_mode = 1'b1, crc_err = 1'b0, fas_err = 1'b0;
   logic       sec_tick = 1'b0, auto_en = 1'b0, global_upd = 1'b0;
   logic       host_cs = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
   logic [1:0] host_addr = 2'd0;
   logic [7:0] host_rdata;

   int total = 0;
   int bad   = 0;

   always #(CLK_P/2) clk = ~clk;

   pmon_err_bank dut_i (
      .clk (clk), .rst_n (rst_n), .esf_mode (esf_mode),
      .crc_err (crc_err), .fas_err (fas_err), .sec_tick (sec_tick),
      .auto_en (auto_en), .global_upd (global_upd), .host_cs (host_cs),
      .host_wr (host_wr), .host_rd (host_rd), .host_addr (host_addr),
      .host_rdata (host_rdata)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic read_reg(input logic [1:0] a, output int v);
      @(negedge clk);
      host_cs = 1'b1; host_rd = 1'b1; host_addr = a;
      @(negedge clk);
      v = int'(host_rdata);
      host_cs = 1'b0; host_rd = 1'b0;
   endtask

   task automatic read_counts(output int blk, output int frm);
      int lo, hi;
      read_reg(2'd0, lo); read_reg(2'd1, hi); blk = hi * 256 + lo;
      read_reg(2'd2, lo); read_reg(2'd3, hi); frm = hi * 256 + lo;
   endtask

   task automatic events(input int n, input logic c, input logic f);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         crc_err = c; fas_err = f;
      end
      @(negedge clk);
      crc_err = 1'b0; fas_err = 1'b0;
   endtask

   // kind 0: host write, 1: tick, 2: global
   task automatic trigger(input int kind, input logic [1:0] a);
      @(negedge clk);
      case (kind)
         0: begin host_cs = 1'b1; host_wr = 1'b1; host_addr = a; end
         1: sec_tick = 1'b1;
         default: global_upd = 1'b1;
      endcase
      @(negedge clk);
      host_cs = 1'b0; host_wr = 1'b0; sec_tick = 1'b0; global_upd = 1'b0;
   endtask

   task automatic t_reset();
      int b, f;
      check("R1 rdata after reset", int'(host_rdata), 0);
      trigger(2, 2'd0);
      read_counts(b, f);
      check("R1 block acc zero", b, 0);
      check("R1 framing acc zero", f, 0);
   endtask

   task automatic t_esf();
      int b, f;
      esf_mode = 1'b1;
      events(7, 1'b1, 1'b0);
      events(3, 1'b0, 1'b1);
      trigger(0, 2'd0);
      read_counts(b, f);
      check("R2 ESF block counts CRC only", b, 7);
      check("R4 framing in ESF", f, 3);
   endtask

   task automatic t_sf();
      int b, f;
      esf_mode = 1'b0;
      events(5, 1'b1, 1'b0);
      events(9, 1'b0, 1'b1);
      trigger(0, 2'd3);
      read_counts(b, f);
      check("R3 SF block counts FAS only", b, 9);
      check("R4 framing in SF", f, 9);
      esf_mode = 1'b1;
   endtask

   task automatic t_wr_addrs();
      int b, f;
      for (int a = 0; a < 4; a++) begin
         events(a + 2, 1'b1, 1'b1);
         trigger(0, 2'(a));
         read_counts(b, f);
         check($sformatf("R5 write addr %0d block", a), b, a + 2);
         check($sformatf("R5 write addr %0d framing", a), f, a + 2);
      end
   endtask

   task automatic t_auto();
      int b, f;
      events(4, 1'b1, 1'b0);
      trigger(0, 2'd1);           // holding = 4,0
      events(5, 1'b0, 1'b1);
      auto_en = 1'b0;
      trigger(1, 2'd0);
      read_counts(b, f);
      check("R6 tick ignored when disabled block", b, 4);
      check("R6 tick ignored when disabled framing", f, 0);
      auto_en = 1'b1;
      trigger(1, 2'd0);
      read_counts(b, f);
      check("R6 tick latches when enabled", f, 5);
      auto_en = 1'b0;
   endtask

   task automatic t_global();
      int b, f;
      events(11, 1'b1, 1'b0);
      trigger(2, 2'd0);
      read_counts(b, f);
      check("R7 global strobe block", b, 11);
      check("R7 global strobe framing", f, 0);
   endtask

   task automatic t_same_cycle();
      int b, f;
      events(3, 1'b1, 1'b0);
      @(negedge clk);
      global_upd = 1'b1; crc_err = 1'b1; fas_err = 1'b1;
      @(negedge clk);
      global_upd = 1'b0; crc_err = 1'b0; fas_err = 1'b0;
      read_counts(b, f);
      check("R8 latch excludes same-cycle block", b, 3);
      check("R8 latch excludes same-cycle framing", f, 0);
      events(2, 1'b1, 1'b0);
      trigger(2, 2'd0);
      read_counts(b, f);
      check("R8 same-cycle event in new block", b, 3);
      check("R8 same-cycle event in new framing", f, 1);
   endtask

   task automatic t_multi();
      int b, f;
      events(4, 1'b0, 1'b1);
      auto_en = 1'b1;
      @(negedge clk);
      host_cs = 1'b1; host_wr = 1'b1; host_addr = 2'd2;
      sec_tick = 1'b1; global_upd = 1'b1;
      @(negedge clk);
      host_cs = 1'b0; host_wr = 1'b0; sec_tick = 1'b0; global_upd = 1'b0;
      auto_en = 1'b0;
      read_counts(b, f);
      check("R10 merged triggers block", b, 0);
      check("R10 merged triggers framing", f, 4);
      trigger(2, 2'd0);
      read_counts(b, f);
      check("R10 single clear framing", f, 0);
   endtask

   task automatic t_saturate();
      int b, f, v;
      esf_mode = 1'b0;
      events(600, 1'b0, 1'b1);
      trigger(0, 2'd0);
      read_counts(b, f);
      check("R9 framing saturates", f, 511);
      check("R3 SF block 600", b, 600);
      read_reg(2'd3, v);
      check("R11 framing high byte", v, 1);
      esf_mode = 1'b1;
      events(4100, 1'b1, 1'b0);
      trigger(0, 2'd0);
      read_counts(b, f);
      check("R9 block saturates", b, 4095);
      read_reg(2'd1, v);
      check("R11 block high byte", v, 15);
      read_reg(2'd0, v);
      check("R11 block low byte", v, 255);
   endtask

   task automatic t_hold_stable();
      int b, f;
      events(6, 1'b1, 1'b1);
      read_counts(b, f);
      check("R11 holding unchanged between latches block", b, 4095);
      check("R11 holding unchanged between latches framing", f, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_esf();
      t_sf();
      t_wr_addrs();
      t_auto();
      t_global();
      t_same_cycle();
      t_multi();
      t_saturate();
      t_hold_stable();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule